// File: doc/BRIEF.md
# Progressive-Scan CCD Line and Frame Timing Generator

This block turns one pixel-rate clock into the digital timing a progressive-scan CCD area sensor needs. It counts bit positions within a line and lines within a frame. From those two counts it builds the following outputs:

- a line strobe and a frame strobe;
- an enable for the horizontal shift clocks and an enable for the reset gate;
- a drive-level code for each of the four vertical transfer phases.

Every output bit also carries a region tag (dummy, optical black, effective or blank) and, on effective pixels, a colour tag taken from the mosaic.

Level shifting, the vertical driver, sampling and conversion, and exposure control all sit outside the block. A start pulse arms the generator, and it then runs frame after frame. By default a line is 780 bits and a frame is 525 lines. Within a line the order is 16 dummy bits, 2 black bits, 659 effective bits and 34 black bits, followed by blanking. The frame starts with 4 dummy lines, then 8 black lines, 494 effective lines and 2 black lines; the lines after those are blanking. One blanking line is the charge-readout line, on which phases 1 and 3 are each pulsed to the high level.

Top module: `ccd_timing_gen`

## Requirements
- R1: After a synchronous reset, and until start is sampled high, all of the following hold: hd, vd, h_en and rg_en are 0, every vph output is 00, region is 0000 and pix_color is 11.
- R2: When start is sampled high at a clock edge while the block is idle, the outputs for line 0, bit 0 appear after the next edge. After that, the outputs for each later position appear one cycle after the previous one. Start has no effect while the block is running.
- R3: hd is 1 for exactly one cycle per line, at bit 0, and a line is LINE_BITS cycles long.
- R4: A frame is FRAME_LINES lines long and then wraps to line 0. vd is 1 only together with hd on line 0.
- R5: On an effective line, the bits from the line start are classed in this order: H_DUMMY dummy bits, H_OB_LEAD black bits, H_ACTIVE effective bits, H_OB_TRAIL black bits, and then blank up to the end of the line.
- R6: Across the frame, the lines from line 0 are classed in this order: V_DUMMY dummy lines, V_OB_LEAD black lines, V_ACTIVE effective lines, V_OB_TRAIL black lines, and then blank lines.
- R7: region is one-hot while running, with bit 0 for dummy, bit 1 for black, bit 2 for effective and bit 3 for blank. A bit whose row class or column class is blank is blank. Otherwise dummy wins over black, and black wins over effective.
- R8: h_en and rg_en are equal. They are 1 exactly on bits 0 to H_SHIFT-1 of every line except READ_LINE, and they are 0 while a blanking transfer segment runs.
- R9: On every line except READ_LINE, segment k covers bits VX_EDGE[k] to VX_EDGE[k+1]-1, for k from 0 to 6. In each segment, the phases at the intermediate level are, in turn: {1,2,3}, {2,3}, {2,3,4}, {3,4}, {1,3,4}, {1,4}, {1,2,4}. Outside the segments only phases 1 and 2 are at the intermediate level. Every phase not listed is low.
- R10: On READ_LINE, phase 1 is high on bits RD_A_START to RD_A_START+RD_WIDTH-1 and phase 3 is high on bits RD_B_START to RD_B_START+RD_WIDTH-1. Otherwise the phases hold the idle pattern. Phases 2 and 4 are never high.
- R11: The level code is 00 for low, 01 for intermediate and 10 for high. The code 11 never appears.
- R12: On effective pixels, pix_color is 01 (G) or 10 (B) on even effective rows, and 00 (R) or 01 (G) on odd effective rows. The first of each pair is used on even effective columns. Parity is counted from the first effective row and the first effective column. pix_color is 11 on every other bit.
- R13: A synchronous reset during a run returns every output to the R1 idle values on the next edge. The block then stays idle until start is given again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Arms the generator when it is idle |
| hd | output | 1 | Line strobe at bit 0 |
| vd | output | 1 | Frame strobe, coincident with hd on line 0 |
| h_en | output | 1 | Horizontal shift-clock enable |
| rg_en | output | 1 | Reset-gate enable |
| vph1 | output | 2 | Vertical phase 1 level code |
| vph2 | output | 2 | Vertical phase 2 level code |
| vph3 | output | 2 | Vertical phase 3 level code |
| vph4 | output | 2 | Vertical phase 4 level code |
| region | output | 4 | One-hot region tag {blank, effective, black, dummy} |
| pix_color | output | 2 | Mosaic colour of an effective pixel, 11 otherwise |

## Verification
The assertions assume three things about the configuration:

- The transfer edge table is strictly increasing and lies within the blanking bits.
- READ_LINE is a blank line.
- Both readout pulses end within the line.

Under those assumptions, h_en implies the idle phase pattern, and the even phases never reach the high level. The bench uses a small geometry that keeps all three properties. It holds reset before any check and pulses start only at a falling edge. The bench therefore never drives an input that the assumptions rule out.

// File: rtl/ccd_timing_gen.sv
module ccd_timing_gen #(
  parameter int LINE_BITS   = 780,
  parameter int FRAME_LINES = 525,
  parameter int H_DUMMY     = 16,
  parameter int H_OB_LEAD   = 2,
  parameter int H_ACTIVE    = 659,
  parameter int H_OB_TRAIL  = 34,
  parameter int V_DUMMY     = 4,
  parameter int V_OB_LEAD   = 8,
  parameter int V_ACTIVE    = 494,
  parameter int V_OB_TRAIL  = 2,
  parameter int READ_LINE   = 524,
  parameter int RD_A_START  = 276,
  parameter int RD_B_START  = 399,
  parameter int RD_WIDTH    = 62,
  parameter int VX_EDGE [8] = '{712, 720, 728, 736, 744, 752, 760, 768}
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output logic       hd,
  output logic       vd,
  output logic       h_en,
  output logic       rg_en,
  output logic [1:0] vph1,
  output logic [1:0] vph2,
  output logic [1:0] vph3,
  output logic [1:0] vph4,
  output logic [3:0] region,
  output logic [1:0] pix_color
);

  localparam int HW      = $clog2(LINE_BITS);
  localparam int VW      = $clog2(FRAME_LINES);
  localparam int H_OB0   = H_DUMMY;
  localparam int H_ACT0  = H_OB0 + H_OB_LEAD;
  localparam int H_OB1   = H_ACT0 + H_ACTIVE;
  localparam int H_SHIFT = H_OB1 + H_OB_TRAIL;
  localparam int V_OB0   = V_DUMMY;
  localparam int V_ACT0  = V_OB0 + V_OB_LEAD;
  localparam int V_OB1   = V_ACT0 + V_ACTIVE;
  localparam int V_USED  = V_OB1 + V_OB_TRAIL;

  localparam logic [1:0] LV_LOW  = 2'b00;
  localparam logic [1:0] LV_MID  = 2'b01;
  localparam logic [1:0] LV_HIGH = 2'b10;
  localparam logic [1:0] C_R     = 2'b00;
  localparam logic [1:0] C_G     = 2'b01;
  localparam logic [1:0] C_B     = 2'b10;
  localparam logic [1:0] C_NONE  = 2'b11;
  localparam logic [3:0] IDLE_MASK = 4'b0011;

  function automatic logic [3:0] seg_mask(input int k);
    case (k)
      0:       seg_mask = 4'b0111;
      1:       seg_mask = 4'b0110;
      2:       seg_mask = 4'b1110;
      3:       seg_mask = 4'b1100;
      4:       seg_mask = 4'b1101;
      5:       seg_mask = 4'b1001;
      default: seg_mask = 4'b1011;
    endcase
  endfunction

  logic          run;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  int            hpos, vpos;

  assign hpos = int'(hcnt);
  assign vpos = int'(vcnt);

  wire h_last = hcnt == HW'(LINE_BITS - 1);
  wire v_last = vcnt == VW'(FRAME_LINES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      run  <= 1'b0;
      hcnt <= '0;
      vcnt <= '0;
    end else if (!run) begin
      run  <= start;
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      hcnt <= h_last ? '0 : hcnt + 1'b1;
      if (h_last) vcnt <= v_last ? '0 : vcnt + 1'b1;
    end
  end

  wire c_dummy = hpos < H_OB0;
  wire c_ob    = (hpos >= H_OB0 && hpos < H_ACT0) || (hpos >= H_OB1 && hpos < H_SHIFT);
  wire c_blank = hpos >= H_SHIFT;
  wire r_dummy = vpos < V_OB0;
  wire r_ob    = (vpos >= V_OB0 && vpos < V_ACT0) || (vpos >= V_OB1 && vpos < V_USED);
  wire r_blank = vpos >= V_USED;
  wire readout = vpos == READ_LINE;

  logic [3:0] reg_n;
  always_comb begin
    if (c_blank || r_blank)      reg_n = 4'b1000;
    else if (c_dummy || r_dummy) reg_n = 4'b0001;
    else if (c_ob || r_ob)       reg_n = 4'b0010;
    else                         reg_n = 4'b0100;
  end

  logic       vx_on;
  logic [3:0] vx_mask;
  always_comb begin
    vx_on   = 1'b0;
    vx_mask = IDLE_MASK;
    for (int k = 0; k < 7; k++) begin
      if (hpos >= VX_EDGE[k] && hpos < VX_EDGE[k+1]) begin
        vx_on   = 1'b1;
        vx_mask = seg_mask(k);
      end
    end
  end

  wire in_rd_a = hpos >= RD_A_START && hpos < RD_A_START + RD_WIDTH;
  wire in_rd_b = hpos >= RD_B_START && hpos < RD_B_START + RD_WIDTH;

  wire [3:0] on_mask = readout ? IDLE_MASK : vx_mask;
  wire [3:0] hi_mask = readout ? {1'b0, in_rd_b, 1'b0, in_rd_a} : 4'b0000;
  logic [7:0] lvl_n;

  for (genvar i = 0; i < 4; i++) begin : g_phase
    assign lvl_n[2*i +: 2] = hi_mask[i] ? LV_HIGH : (on_mask[i] ? LV_MID : LV_LOW);
  end

  wire shift_n = !c_blank && !readout && !vx_on;

  logic [1:0] col_n;
  wire row_odd = ((vpos - V_ACT0) % 2) != 0;
  wire col_odd = ((hpos - H_ACT0) % 2) != 0;
  always_comb begin
    if (!reg_n[2])    col_n = C_NONE;
    else if (row_odd) col_n = col_odd ? C_G : C_R;
    else              col_n = col_odd ? C_B : C_G;
  end

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      hd        <= 1'b0;
      vd        <= 1'b0;
      h_en      <= 1'b0;
      rg_en     <= 1'b0;
      vph1      <= LV_LOW;
      vph2      <= LV_LOW;
      vph3      <= LV_LOW;
      vph4      <= LV_LOW;
      region    <= 4'b0000;
      pix_color <= C_NONE;
    end else begin
      hd        <= hcnt == '0;
      vd        <= hcnt == '0 && vcnt == '0;
      h_en      <= shift_n;
      rg_en     <= shift_n;
      vph1      <= lvl_n[1:0];
      vph2      <= lvl_n[3:2];
      vph3      <= lvl_n[5:4];
      vph4      <= lvl_n[7:6];
      region    <= reg_n;
      pix_color <= col_n;
    end
  end

  p_hd_single_r3: assert property (@(posedge clk) disable iff (rst) hd |=> !hd);
  p_line_wrap_r3: assert property (@(posedge clk) disable iff (rst) (run && h_last) |=> hcnt == '0);
  p_vd_with_hd_r4: assert property (@(posedge clk) disable iff (rst) vd |-> hd);
  p_region_onehot_r7: assert property (@(posedge clk) disable iff (rst) $onehot0(region));
  p_shift_idle_phases_r8: assert property (@(posedge clk) disable iff (rst)
    h_en |-> (vph1 == LV_MID && vph2 == LV_MID && vph3 == LV_LOW && vph4 == LV_LOW));
  p_en_pair_r8: assert property (@(posedge clk) disable iff (rst) h_en == rg_en);
  p_even_never_high_r10: assert property (@(posedge clk) disable iff (rst)
    vph2 != LV_HIGH && vph4 != LV_HIGH);
  p_no_bad_code_r11: assert property (@(posedge clk) disable iff (rst)
    vph1 != 2'b11 && vph2 != 2'b11 && vph3 != 2'b11 && vph4 != 2'b11);
  p_color_eff_r12: assert property (@(posedge clk) disable iff (rst)
    (pix_color != C_NONE) == region[2]);
  p_reset_idle_r13: assert property (@(posedge clk) $past(rst) |-> (!hd && region == 4'b0000));

endmodule

// File: tb/ccd_timing_gen_test.sv
`timescale 1ns/1ps
module ccd_timing_gen_test;
  localparam int LB = 40, FL = 20;
  localparam int HDUM = 3, HOBL = 2, HACT = 9, HOBT = 4;
  localparam int VDUM = 2, VOBL = 3, VACT = 6, VOBT = 2;
  localparam int RDL = 17, RDA = 5, RDB = 14, RDW = 4;
  localparam int EDGE [8] = '{20, 22, 24, 26, 28, 30, 32, 34};
  localparam int FRAME = LB * FL;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic hd, vd, h_en, rg_en;
  logic [1:0] vph1, vph2, vph3, vph4, pix_color;
  logic [3:0] region;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ccd_timing_gen #(
    .LINE_BITS(LB), .FRAME_LINES(FL),
    .H_DUMMY(HDUM), .H_OB_LEAD(HOBL), .H_ACTIVE(HACT), .H_OB_TRAIL(HOBT),
    .V_DUMMY(VDUM), .V_OB_LEAD(VOBL), .V_ACTIVE(VACT), .V_OB_TRAIL(VOBT),
    .READ_LINE(RDL), .RD_A_START(RDA), .RD_B_START(RDB), .RD_WIDTH(RDW),
    .VX_EDGE(EDGE)
  ) uut (
    .clk(clk), .rst(rst), .start(start), .hd(hd), .vd(vd), .h_en(h_en), .rg_en(rg_en),
    .vph1(vph1), .vph2(vph2), .vph3(vph3), .vph4(vph4),
    .region(region), .pix_color(pix_color)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_idle(input string req);
    chk(hd == 1'b0 && vd == 1'b0, req, "strobes", {hd, vd}, 0);
    chk(h_en == 1'b0 && rg_en == 1'b0, req, "enables", {h_en, rg_en}, 0);
    chk({vph4, vph3, vph2, vph1} == 8'h00, req, "phases", {vph4, vph3, vph2, vph1}, 0);
    chk(region == 4'b0000, req, "region", region, 0);
    chk(pix_color == 2'b11, req, "color", pix_color, 3);
  endtask

  function automatic int cls(input int p, input int d, input int ol, input int a, input int ot);
    if (p < d) return 0;
    if (p < d + ol) return 1;
    if (p < d + ol + a) return 2;
    if (p < d + ol + a + ot) return 1;
    return 3;
  endfunction

  function automatic logic [3:0] smask(input int k);
    logic [3:0] t [7] = '{4'b0111, 4'b0110, 4'b1110, 4'b1100, 4'b1101, 4'b1001, 4'b1011};
    return t[k];
  endfunction

  task automatic check_pos(input int n);
    int p, l, b, c, r, seg;
    logic [3:0] er, onm;
    logic [7:0] elv;
    logic [1:0] ec;
    bit een;
    string rt;
    p = n % FRAME; l = p / LB; b = p % LB;
    c = cls(b, HDUM, HOBL, HACT, HOBT);
    r = cls(l, VDUM, VOBL, VACT, VOBT);
    chk(hd == (b == 0), "R3", "hd", hd, b == 0);
    chk(vd == (b == 0 && l == 0), "R4", "vd", vd, b == 0 && l == 0);
    if (c == 3 || r == 3) er = 4'b1000;
    else if (c == 0 || r == 0) er = 4'b0001;
    else if (c == 1 || r == 1) er = 4'b0010;
    else er = 4'b0100;
    rt = (r == 2) ? "R5" : (c == 2) ? "R6" : "R7";
    chk(region == er, rt, "region", region, er);
    seg = -1;
    for (int k = 0; k < 7; k++) if (b >= EDGE[k] && b < EDGE[k+1]) seg = k;
    een = (c != 3) && (l != RDL) && (seg < 0);
    chk(h_en == een, "R8", "h_en", h_en, een);
    chk(rg_en == een, "R8", "rg_en", rg_en, een);
    onm = (l == RDL || seg < 0) ? 4'b0011 : smask(seg);
    for (int i = 0; i < 4; i++) elv[2*i +: 2] = onm[i] ? 2'b01 : 2'b00;
    if (l == RDL && b >= RDA && b < RDA + RDW) elv[1:0] = 2'b10;
    if (l == RDL && b >= RDB && b < RDB + RDW) elv[5:4] = 2'b10;
    chk({vph4, vph3, vph2, vph1} == elv, (l == RDL) ? "R10" : "R9", "phases",
        {vph4, vph3, vph2, vph1}, elv);
    chk(vph1 != 2'b11 && vph2 != 2'b11 && vph3 != 2'b11 && vph4 != 2'b11, "R11", "code",
        {vph4, vph3, vph2, vph1}, elv);
    if (er != 4'b0100) ec = 2'b11;
    else if ((l - VDUM - VOBL) % 2 == 0) ec = ((b - HDUM - HOBL) % 2 == 0) ? 2'b01 : 2'b10;
    else ec = ((b - HDUM - HOBL) % 2 == 0) ? 2'b00 : 2'b01;
    chk(pix_color == ec, "R12", "color", pix_color, ec);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check_idle("R1");
    rst = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check_idle("R1");
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check_idle("R2");
    for (int n = 0; n < 2 * FRAME + 60; n++) begin
      if (n == 300) start = 1'b1;
      if (n == 302) start = 1'b0;
      @(negedge clk);
      check_pos(n);
    end
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_idle("R13");
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check_idle("R13");
    end
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check_idle("R2");
    for (int n = 0; n < LB + 6; n++) begin
      @(negedge clk);
      check_pos(n);
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule